// File: doc/BRIEF.md
# Low-Pin-Count / Firmware-Hub Memory Header Decoder

This block sits on the target side of a 4-bit multiplexed flash bus that has an active-low frame strobe. It samples the nibble bus on every clock and recovers the header of each memory cycle. First it classifies the start nibble as a plain low-pin-count (LPC) memory cycle or a firmware-hub (FWH) cycle. It then takes the direction from the start nibble (FWH) or from the cycle-type nibble (LPC), captures the FWH device-select nibble, and assembles the address. Nibbles arrive most significant first. An FWH address has 28 bits and is zero-extended to the 32-bit output.

When the last address nibble has been sampled, the decoded header is presented with a one-clock valid pulse. The result registers then hold their values until the next pulse. If the frame strobe is asserted again during an address phase, the cycle in flight is dropped, a one-clock abort pulse is raised, and the new start nibble is taken. Two parameters enable each framing separately, so that a target that accepts only one framing ignores cycles of the other. The turnaround, sync and data phases are left to downstream logic.

Top module: `lpcfwh_hdr_decoder`

## Requirements
- R1: Start nibble 4'hD is an FWH read and 4'hE is an FWH write. The next nibble is the device select, captured on `sel_o` whatever its value. Seven address nibbles follow, most significant first, and `addr_o` shows them with bits 31:28 zero.
- R2: Start nibble 4'h0 is an LPC cycle. The next nibble with bits [3:2]=01 is a memory cycle, and bit 1 gives the direction (1 = write). Bit 0 is ignored. Eight address nibbles follow, most significant first. `sel_o` reads 0 and `is_fwh_o` reads 0.
- R3: An LPC cycle-type nibble whose bits [3:2] differ from 01 produces no valid pulse and leaves every result output unchanged.
- R4: Any start nibble other than 4'h0, 4'hD and 4'hE produces no valid pulse.
- R5: While the frame strobe stays low for several clocks, only the nibble sampled on its last low clock counts as the start.
- R6: Frame low during an address phase raises `abort_o` for exactly one clock and gives no valid pulse for that cycle. The new start is decoded normally.
- R7: `hdr_valid_o` rises in the clock after the last address nibble is sampled and lasts one clock. `addr_o`, `sel_o`, `is_fwh_o` and `is_write_o` change only together with a valid pulse.
- R8: With `EN_FWH=0`, FWH starts are ignored. With `EN_LPC=0`, LPC starts are ignored. Neither gives a pulse.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_ni | input | 1 | Active-low frame strobe |
| nib_i | input | 4 | Multiplexed nibble bus |
| hdr_valid_o | output | 1 | One-clock pulse: header decoded |
| is_fwh_o | output | 1 | 1 = firmware-hub framing, 0 = LPC |
| is_write_o | output | 1 | 1 = write, 0 = read |
| sel_o | output | 4 | FWH device select (0 for LPC) |
| addr_o | output | 32 | Decoded address |
| abort_o | output | 1 | One-clock pulse: address phase cut short by a new frame |

## Verification
All 16 select values in both FWH directions and all 16 LPC cycle-type nibbles are driven, each with its own arithmetic address pattern. This separates select capture, direction decoding, the ignored reserved bit and the non-memory type rejection. A sweep of all 16 start nibbles followed by an identical tail tells the three accepted codes from the rest. Three instances share the bus: both framings enabled, LPC only, and FWH only, which shows that a framing which is switched off gives no pulse. Extended frame strobes and a strobe that returns in the middle of an address phase exercise start selection and the abort path.

// File: rtl/lpcfwh_pkg.sv
package lpcfwh_pkg;

  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] START_LPC    = 4'h0;
  localparam logic [NIB_W-1:0] START_FWH_RD = 4'hD;
  localparam logic [NIB_W-1:0] START_FWH_WR = 4'hE;

  localparam logic [1:0] LPC_MEM_CLASS = 2'b01;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_START = 2'd1,
    HS_ADDR  = 2'd2
  } hdr_state_e;

endpackage

// File: rtl/lpcfwh_field_decode.sv
module lpcfwh_field_decode
  import lpcfwh_pkg::*;
#(
  parameter bit EN_LPC   = 1'b1,
  parameter bit EN_FWH   = 1'b1,
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 4
) (
  input  logic [NIB_W-1:0] start_i,
  input  logic [NIB_W-1:0] field_i,
  output logic             accept_o,
  output logic             fwh_o,
  output logic             write_o,
  output logic [NIB_W-1:0] sel_o,
  output logic [CNT_W-1:0] nibs_o
);

  localparam int LPC_NIBS = ADDR_W / NIB_W;
  localparam int FWH_NIBS = LPC_NIBS - 1;

  always_comb begin
    accept_o = 1'b0;
    fwh_o    = 1'b0;
    write_o  = 1'b0;
    sel_o    = '0;
    nibs_o   = '0;
    unique case (start_i)
      START_FWH_RD, START_FWH_WR: begin
        if (EN_FWH) begin
          accept_o = 1'b1;
          fwh_o    = 1'b1;
          write_o  = (start_i == START_FWH_WR);
          sel_o    = field_i;
          nibs_o   = CNT_W'(FWH_NIBS);
        end
      end
      START_LPC: begin
        if (EN_LPC && (field_i[3:2] == LPC_MEM_CLASS)) begin
          accept_o = 1'b1;
          write_o  = field_i[1];
          nibs_o   = CNT_W'(LPC_NIBS);
        end
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/lpcfwh_addr_shift.sv
module lpcfwh_addr_shift
  import lpcfwh_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic [ADDR_W-1:0] addr_next_o
);

  localparam int SLOTS = ADDR_W / NIB_W - 1;

  logic [NIB_W-1:0] slot_q [SLOTS];
  logic [NIB_W-1:0] slot_d [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g == 0) begin : g_head
      assign slot_d[g] = nib_i;
    end else begin : g_tail
      assign slot_d[g] = slot_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
      end else if (clr_i) begin
        slot_q[g] <= '0;
      end else if (en_i) begin
        slot_q[g] <= slot_d[g];
      end
    end

    assign addr_next_o[NIB_W*(g+1) +: NIB_W] = slot_q[g];
  end

  assign addr_next_o[NIB_W-1:0] = nib_i;

endmodule

// File: rtl/lpcfwh_hdr_ctrl.sv
module lpcfwh_hdr_ctrl
  import lpcfwh_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              acc_i,
  input  logic              acc_fwh_i,
  input  logic              acc_write_i,
  input  logic [NIB_W-1:0]  acc_sel_i,
  input  logic [CNT_W-1:0]  acc_nibs_i,
  input  logic [ADDR_W-1:0] addr_next_i,
  output logic [NIB_W-1:0]  start_o,
  output logic              shift_clr_o,
  output logic              shift_en_o,
  output logic              hdr_valid_o,
  output logic              is_fwh_o,
  output logic              is_write_o,
  output logic [NIB_W-1:0]  sel_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              abort_o
);

  hdr_state_e       state_q, state_d;
  logic [NIB_W-1:0] start_q, start_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fwh_q, fwh_d;
  logic             wr_q, wr_d;
  logic [NIB_W-1:0] sel_q, sel_d;
  logic             fire, abort_now;

  always_comb begin
    state_d     = state_q;
    start_d     = start_q;
    cnt_d       = cnt_q;
    fwh_d       = fwh_q;
    wr_d        = wr_q;
    sel_d       = sel_q;
    shift_clr_o = 1'b0;
    shift_en_o  = 1'b0;
    fire        = 1'b0;
    abort_now   = 1'b0;
    if (!frame_ni) begin
      state_d   = HS_START;
      start_d   = nib_i;
      abort_now = (state_q == HS_ADDR);
    end else begin
      unique case (state_q)
        HS_START: begin
          if (acc_i) begin
            state_d     = HS_ADDR;
            cnt_d       = acc_nibs_i;
            fwh_d       = acc_fwh_i;
            wr_d        = acc_write_i;
            sel_d       = acc_sel_i;
            shift_clr_o = 1'b1;
          end else begin
            state_d = HS_IDLE;
          end
        end
        HS_ADDR: begin
          shift_en_o = 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            fire    = 1'b1;
            state_d = HS_IDLE;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        default: state_d = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      start_q <= '0;
      cnt_q   <= '0;
      fwh_q   <= 1'b0;
      wr_q    <= 1'b0;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      fwh_q   <= fwh_d;
      wr_q    <= wr_d;
      sel_q   <= sel_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_valid_o <= 1'b0;
      abort_o     <= 1'b0;
    end else begin
      hdr_valid_o <= fire;
      abort_o     <= abort_now;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_fwh_o   <= 1'b0;
      is_write_o <= 1'b0;
      sel_o      <= '0;
      addr_o     <= '0;
    end else if (fire) begin
      is_fwh_o   <= fwh_q;
      is_write_o <= wr_q;
      sel_o      <= sel_q;
      addr_o     <= addr_next_i;
    end
  end

  assign start_o = start_q;

endmodule

// File: rtl/lpcfwh_hdr_decoder.sv
module lpcfwh_hdr_decoder
  import lpcfwh_pkg::*;
#(
  parameter bit EN_LPC = 1'b1,
  parameter bit EN_FWH = 1'b1,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic [3:0]        nib_i,
  output logic              hdr_valid_o,
  output logic              is_fwh_o,
  output logic              is_write_o,
  output logic [3:0]        sel_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              abort_o
);

  localparam int LPC_NIBS = ADDR_W / NIB_W;
  localparam int CNT_W    = $clog2(LPC_NIBS + 1);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [NIB_W-1:0]  start_nib;
  logic              acc, acc_fwh, acc_write;
  logic [NIB_W-1:0]  acc_sel;
  logic [CNT_W-1:0]  acc_nibs;
  logic              shift_clr, shift_en;
  logic [ADDR_W-1:0] addr_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  lpcfwh_field_decode #(
    .EN_LPC (EN_LPC),
    .EN_FWH (EN_FWH),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_decode (
    .start_i  (start_nib),
    .field_i  (nib_i),
    .accept_o (acc),
    .fwh_o    (acc_fwh),
    .write_o  (acc_write),
    .sel_o    (acc_sel),
    .nibs_o   (acc_nibs)
  );

  lpcfwh_addr_shift #(
    .ADDR_W (ADDR_W)
  ) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .clr_i       (shift_clr),
    .en_i        (shift_en),
    .nib_i       (nib_i),
    .addr_next_o (addr_next)
  );

  lpcfwh_hdr_ctrl #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .frame_ni    (frame_ni),
    .nib_i       (nib_i),
    .acc_i       (acc),
    .acc_fwh_i   (acc_fwh),
    .acc_write_i (acc_write),
    .acc_sel_i   (acc_sel),
    .acc_nibs_i  (acc_nibs),
    .addr_next_i (addr_next),
    .start_o     (start_nib),
    .shift_clr_o (shift_clr),
    .shift_en_o  (shift_en),
    .hdr_valid_o (hdr_valid_o),
    .is_fwh_o    (is_fwh_o),
    .is_write_o  (is_write_o),
    .sel_o       (sel_o),
    .addr_o      (addr_o),
    .abort_o     (abort_o)
  );

endmodule

// File: rtl/lpcfwh_hdr_checker.sv
module lpcfwh_hdr_checker #(
  parameter bit EN_LPC = 1'b1,
  parameter bit EN_FWH = 1'b1,
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_ni,
  input logic              hdr_valid_o,
  input logic              is_fwh_o,
  input logic              is_write_o,
  input logic [3:0]        sel_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              abort_o
);

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |=> !hdr_valid_o); // R7

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdr_valid_o |-> ($stable(addr_o) && $stable(sel_o) && $stable(is_fwh_o) && $stable(is_write_o))); // R7

  AST_FWH_ZERO_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_o && is_fwh_o) |-> (addr_o[ADDR_W-1 -: 4] == 4'h0)); // R1

  AST_LPC_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_o && !is_fwh_o) |-> (sel_o == 4'h0)); // R2

  AST_VALID_FRAME_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> $past(frame_ni)); // R5

  AST_ABORT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !$past(frame_ni)); // R6

  AST_ABORT_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(abort_o && hdr_valid_o)); // R6

  AST_ENABLED_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_o |-> (is_fwh_o ? EN_FWH : EN_LPC)); // R8

endmodule

bind lpcfwh_hdr_decoder lpcfwh_hdr_checker #(
  .EN_LPC (EN_LPC),
  .EN_FWH (EN_FWH),
  .ADDR_W (ADDR_W)
) u_hdr_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_ni    (frame_ni),
  .hdr_valid_o (hdr_valid_o),
  .is_fwh_o    (is_fwh_o),
  .is_write_o  (is_write_o),
  .sel_o       (sel_o),
  .addr_o      (addr_o),
  .abort_o     (abort_o)
);

// File: tb/lpcfwh_hdr_decoder_test.sv
`timescale 1ns/1ps
module lpcfwh_hdr_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n;
  logic [3:0]  nib;

  logic        v_a, f_a, w_a, ab_a;
  logic [3:0]  s_a;
  logic [31:0] a_a;
  logic        v_l, f_l, w_l, ab_l;
  logic [3:0]  s_l;
  logic [31:0] a_l;
  logic        v_f, f_f, w_f, ab_f;
  logic [3:0]  s_f;
  logic [31:0] a_f;

  int checks = 0;
  int fails  = 0;
  int pulses_a = 0, pulses_l = 0, pulses_f = 0, aborts_a = 0;

  always #2.5 clk = ~clk;

  lpcfwh_hdr_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .nib_i(nib),
    .hdr_valid_o(v_a), .is_fwh_o(f_a), .is_write_o(w_a), .sel_o(s_a),
    .addr_o(a_a), .abort_o(ab_a));

  lpcfwh_hdr_decoder #(.EN_LPC(1'b1), .EN_FWH(1'b0)) uut_lpc (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .nib_i(nib),
    .hdr_valid_o(v_l), .is_fwh_o(f_l), .is_write_o(w_l), .sel_o(s_l),
    .addr_o(a_l), .abort_o(ab_l));

  lpcfwh_hdr_decoder #(.EN_LPC(1'b0), .EN_FWH(1'b1)) uut_fwh (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .nib_i(nib),
    .hdr_valid_o(v_f), .is_fwh_o(f_f), .is_write_o(w_f), .sel_o(s_f),
    .addr_o(a_f), .abort_o(ab_f));

  always @(negedge clk) begin
    if (v_a) pulses_a++;
    if (v_l) pulses_l++;
    if (v_f) pulses_f++;
    if (ab_a) aborts_a++;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic drive(input logic f, input logic [3:0] n);
    @(negedge clk);
    frame_n = f;
    nib     = n;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 4'hF);
  endtask

  task automatic send_nibs(input logic [31:0] a, input int cnt);
    for (int i = cnt - 1; i >= 0; i--) drive(1'b1, a[4*i +: 4]);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    frame_n = 1'b1;
    nib     = 4'hF;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", {v_a, f_a, w_a, ab_a, s_a, a_a}, '0);
    rst_n = 1'b1;
    idle(4);

    // R1 + R8: FWH sweep, select x direction
    for (int s = 0; s < 16; s++) begin
      for (int d = 0; d < 2; d++) begin
        logic [27:0] a28;
        int pl;
        a28 = 28'(s * 32'h0123457 + d * 32'h0A5A5A5 + 32'h0300001);
        pl  = pulses_l;
        drive(1'b0, d ? 4'hE : 4'hD);
        drive(1'b1, 4'(s));
        send_nibs({4'h0, a28}, 7);
        drive(1'b1, 4'hF);
        check("R1 fwh header", {v_a, f_a, w_a, s_a, a_a},
              {1'b1, 1'b1, 1'(d), 4'(s), 4'h0, a28});
        check("R8 fwh on fwh-only", {v_f, f_f, s_f, a_f}, {1'b1, 1'b1, 4'(s), 4'h0, a28});
        drive(1'b1, 4'hF);
        check("R7 pulse width", {63'b0, v_a}, 64'd0);
        check("R8 lpc-only ignores fwh", 64'(pulses_l - pl), 64'd0);
        idle(1);
      end
    end

    // R2 + R3 + R8: LPC cycle-type sweep
    for (int t = 0; t < 16; t++) begin
      logic [31:0] a32;
      logic [31:0] prev_addr;
      int pa, pf;
      logic mem;
      a32 = 32'(t) * 32'h1F3D5B79 ^ 32'hC0DE0000;
      prev_addr = a_a;
      pa  = pulses_a;
      pf  = pulses_f;
      mem = (t[3:2] == 2'b01);
      drive(1'b0, 4'h0);
      drive(1'b1, 4'(t));
      send_nibs(a32, 8);
      drive(1'b1, 4'hF);
      if (mem) begin
        check("R2 lpc header", {v_a, f_a, w_a, s_a, a_a},
              {1'b1, 1'b0, 1'(t >> 1), 4'h0, a32});
        check("R8 lpc on lpc-only", {v_l, a_l}, {1'b1, a32});
      end else begin
        check("R3 non-memory type no pulse", 64'(pulses_a - pa), 64'd0);
        check("R3 outputs held", {32'b0, a_a}, {32'b0, prev_addr});
      end
      check("R8 fwh-only ignores lpc", 64'(pulses_f - pf), 64'd0);
      idle(2);
    end

    // R4: start nibble sweep
    for (int s = 0; s < 16; s++) begin
      int pa;
      int exp_p;
      pa = pulses_a;
      exp_p = (s == 0 || s == 13 || s == 14) ? 1 : 0;
      drive(1'b0, 4'(s));
      drive(1'b1, 4'h4);
      send_nibs(32'h89ABCDEF, 8);
      idle(3);
      check("R4 start classification", 64'(pulses_a - pa), 64'(exp_p));
    end

    // R5: long frame, last low nibble counts
    drive(1'b0, 4'hD);
    drive(1'b0, 4'h7);
    drive(1'b0, 4'h0);
    drive(1'b1, 4'h6);
    send_nibs(32'h13572468, 8);
    drive(1'b1, 4'hF);
    check("R5 last start wins", {v_a, f_a, w_a, a_a}, {1'b1, 1'b0, 1'b1, 32'h13572468});
    idle(2);
    drive(1'b0, 4'h0);
    drive(1'b0, 4'hE);
    drive(1'b1, 4'h9);
    send_nibs(32'h0ABCDEF1, 7);
    drive(1'b1, 4'hF);
    check("R5 last start wins fwh", {v_a, f_a, w_a, s_a, a_a},
          {1'b1, 1'b1, 1'b1, 4'h9, 32'h0ABCDEF1});
    idle(2);

    // R6: abort during address phase
    begin
      int pa, ab;
      pa = pulses_a;
      ab = aborts_a;
      drive(1'b0, 4'hD);
      drive(1'b1, 4'h3);
      send_nibs(32'h00000FFF, 3);
      drive(1'b0, 4'h0);
      drive(1'b1, 4'h4);
      check("R6 abort pulse", {63'b0, ab_a}, 64'd1);
      send_nibs(32'hFEDCBA98, 8);
      drive(1'b1, 4'hF);
      check("R6 new cycle decoded", {v_a, f_a, w_a, a_a}, {1'b1, 1'b0, 1'b0, 32'hFEDCBA98});
      idle(2);
      check("R6 one abort one pulse", 64'({pulses_a - pa, aborts_a - ab}), 64'({32'd1, 32'd1}));
    end

    // R7: outputs held across junk traffic
    drive(1'b0, 4'h5);
    drive(1'b1, 4'h4);
    send_nibs(32'h11111111, 8);
    idle(2);
    check("R7 result held", {v_a, f_a, w_a, a_a}, {1'b0, 1'b0, 1'b0, 32'hFEDCBA98});

    summary();
    $finish;
  end

endmodule